// File: doc/BRIEF.md
# Mailbox Command Request Engine

This block is the host side of a request/reply exchange with a coprocessor. A one-cycle `start` pulse picks one of three fixed commands through `cmdSel`. The engine writes the chosen five-word message into a shared message RAM and rings the coprocessor's doorbell mailbox. It then polls the reply mailbox at a fixed interval until the coprocessor posts a nonzero value or the poll budget runs out. After that it reads the reply words back, clears the reply mailbox and reports a result.

Each message has five 32-bit words: a kind word (1 for a command, 2 for a reply), the command code, the argument count, one argument and a checksum. The checksum is the wrapping sum of the other four words. The engine checks the checksum of the reply. It reports a raw result code and a small error number. It also turns the reply's argument word into a pointer that is tagged with the memory it refers to. All traffic goes over one simple valid/ready word bus.

Top module: `mbox_cmd_engine`

## Requirements
- R1: After an accepted start with `cmdSel` below 3, the first five bus operations are writes, in order, to addresses 0x100, 0x104, 0x108, 0x10C and 0x110. They carry {1,1,1,1,4} for index 0, {1,2,1,1,5} for index 1 and {1,2,1,2,6} for index 2.
- R2: A start with `cmdSel` equal to 3 makes no bus operation. It ends with `done` on the second cycle and gives `resultCode`=0x80000002, `errNum`=2, `resultOk`=0 and `ptrSpace`=0. `busValid` is never high while `busy` is low.
- R3: The sixth bus operation writes 1 to address 0x10. The operations after it are reads of address 0x14.
- R4: Consecutive reads of 0x14 are at least POLL_GAP+1 cycles apart. If MAX_POLLS reads all return zero, no reply word is read and the result is 0x80000010 with `errNum`=5.
- R5: The last bus operation of every non-rejected transaction writes 0 to address 0x14. This holds for a timeout as well as for a reply, and it comes in the cycle just before `done`.
- R6: When a read of 0x14 returns a nonzero value, the next five operations read 0x100 to 0x110 in order. If the fifth reply word differs from the 32-bit sum of the first four, the result is 0x80000004 with `errNum`=3.
- R7: When the reply checksum is correct, `resultCode` equals the mailbox value. `resultOk` is 1 exactly when that value is 1, and `errNum` is then 0. Otherwise `errNum` is the 1-based position of the lowest set bit among bits 30:0, or 0 if there is none.
- R8: When `resultOk` is 1, reply word 3 is decoded. Bits 31:28 are a type and bits 27:0 are an offset. Type 1 gives `ptrSpace`=1 with `ptrAddr`=0x100+offset. Type 0 gives `ptrSpace`=2 with `ptrAddr`=offset. Any other type gives `ptrSpace`=3 (fatal) with `ptrAddr`=0. When `resultOk` is 0, `ptrSpace`=0 and `ptrAddr`=0.
- R9: `busy` rises the cycle after an accepted start and stays high through a single-cycle `done` pulse. A start while `busy` is high, including the `done` cycle, is ignored.
- R10: While `busValid` is high and `busReady` is low, `busValid`, `busWrite`, `busAddr` and `busWdata` hold their values into the next cycle. Read data is taken in the cycle where both are high.
- R11: After reset, `busy`, `done` and `busValid` are 0, `resultCode` is 0 and `ptrSpace` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken while idle |
| cmdSel | input | 2 | Command index; 3 is rejected |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| resultCode | output | 32 | Raw result or synthetic error code |
| resultOk | output | 1 | Result code equals 1 |
| errNum | output | 5 | Lowest set bit position of code bits 30:0 |
| ptrSpace | output | 2 | 0 none, 1 message RAM, 2 data memory, 3 fatal |
| ptrAddr | output | 32 | Decoded reply pointer address |
| busValid | output | 1 | Bus request |
| busWrite | output | 1 | 1 write, 0 read |
| busAddr | output | ADDR_W | Byte address |
| busWdata | output | 32 | Write data |
| busReady | input | 1 | Bus accepts the request this cycle |
| busRdata | input | 32 | Read data, valid with the handshake |

## Verification
A new `start` can arrive while a transaction is running, and in particular during the very cycle that `done` is pulsing. The bench drives an extra start in mid-transaction, and another one in the cycle it sees `done`, each carrying a different command index. It then judges that the result matches the original command and that exactly one `done` pulse appears. The bench also checks that no bus activity or second pulse follows in the next cycles. A second collision is between the coprocessor posting a reply and the poll timer running out. Random reply latencies, stalls on `busReady` and a no-reply mode cover both endings, each scored against its own expected bus trace.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int WORD_W    = 32;
  localparam int MSG_WORDS = 5;
  localparam int NUM_CMDS  = 3;

  localparam logic [15:0] MSG_BASE = 16'h0100;
  localparam logic [15:0] TO_COP   = 16'h0010;
  localparam logic [15:0] TO_HOST  = 16'h0014;

  localparam logic [31:0] CODE_OK  = 32'h0000_0001;
  localparam logic [31:0] CODE_REJ = 32'h8000_0002;
  localparam logic [31:0] CODE_CHK = 32'h8000_0004;
  localparam logic [31:0] CODE_TMO = 32'h8000_0010;

  typedef enum logic [1:0] {PTR_NONE, PTR_MSG, PTR_DATA, PTR_BAD} ptrSpace_e;

  typedef enum logic [2:0] {OP_NONE, OP_MSGWR, OP_RING, OP_POLL, OP_FETCH, OP_FREE} busOp_e;

  typedef struct packed {
    busOp_e     op;
    logic [2:0] idx;
    logic       launch;
    logic       grabWord;
    logic       grabMbox;
    logic       timedOut;
    logic       reject;
    logic       finish;
  } ctrlStrb_t;

  // word idx of the built-in message for command index cmd
  function automatic logic [31:0] msgWord(input logic [1:0] cmd, input logic [2:0] idx);
    logic [31:0] opc, arg;
    opc = (cmd == 2'd0) ? 32'd1 : 32'd2;
    arg = (cmd == 2'd2) ? 32'd2 : 32'd1;
    case (idx)
      3'd0: msgWord = 32'd1;
      3'd1: msgWord = opc;
      3'd2: msgWord = 32'd1;
      3'd3: msgWord = arg;
      default: msgWord = 32'd1 + opc + 32'd1 + arg;
    endcase
  endfunction

  function automatic logic [4:0] lowBitPos(input logic [30:0] v);
    lowBitPos = 5'd0;
    for (int i = 30; i >= 0; i--) begin
      if (v[i]) lowBitPos = 5'(i + 1);
    end
  endfunction
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int MAX_POLLS = 200000,
  parameter int POLL_GAP  = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] cmdSel,
  input  logic       busReady,
  input  logic       pollHit,
  output ctrlStrb_t  strb,
  output logic       busy,
  output logic       done
);
  localparam int PCW = $clog2(MAX_POLLS + 1);
  localparam int GCW = $clog2(POLL_GAP + 1);

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_RING, S_POLL, S_GAP, S_FETCH, S_FREE, S_DONE} state_e;

  state_e     state, nState;
  logic [2:0] idx, nIdx;
  logic [PCW-1:0] pollCnt, nPollCnt;
  logic [GCW-1:0] gapCnt, nGapCnt;

  always_comb begin
    strb     = '0;
    strb.idx = idx;
    nState   = state;
    nIdx     = idx;
    nPollCnt = pollCnt;
    nGapCnt  = gapCnt;
    case (state)
      S_IDLE: if (start) begin
        strb.launch = 1'b1;
        nIdx = 3'd0;
        if (int'(cmdSel) >= NUM_CMDS) begin
          strb.reject = 1'b1;
          strb.finish = 1'b1;
          nState = S_DONE;
        end else begin
          nState = S_SEND;
        end
      end
      S_SEND: begin
        strb.op = OP_MSGWR;
        if (busReady) begin
          if (idx == 3'(MSG_WORDS - 1)) nState = S_RING;
          else nIdx = idx + 3'd1;
        end
      end
      S_RING: begin
        strb.op = OP_RING;
        if (busReady) begin
          nState   = S_POLL;
          nPollCnt = '0;
        end
      end
      S_POLL: begin
        strb.op = OP_POLL;
        if (busReady) begin
          if (pollHit) begin
            strb.grabMbox = 1'b1;
            nIdx   = 3'd0;
            nState = S_FETCH;
          end else if (pollCnt == PCW'(MAX_POLLS - 1)) begin
            strb.timedOut = 1'b1;
            nState = S_FREE;
          end else begin
            nPollCnt = pollCnt + 1'b1;
            nGapCnt  = '0;
            nState   = S_GAP;
          end
        end
      end
      S_GAP: begin
        if (gapCnt == GCW'(POLL_GAP - 1)) nState = S_POLL;
        else nGapCnt = gapCnt + 1'b1;
      end
      S_FETCH: begin
        strb.op       = OP_FETCH;
        strb.grabWord = busReady;
        if (busReady) begin
          if (idx == 3'(MSG_WORDS - 1)) nState = S_FREE;
          else nIdx = idx + 3'd1;
        end
      end
      S_FREE: begin
        strb.op = OP_FREE;
        if (busReady) begin
          strb.finish = 1'b1;
          nState = S_DONE;
        end
      end
      default: nState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      idx     <= '0;
      pollCnt <= '0;
      gapCnt  <= '0;
    end else begin
      state   <= nState;
      idx     <= nIdx;
      pollCnt <= nPollCnt;
      gapCnt  <= nGapCnt;
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

  // R9: done only inside a busy window, and only for one cycle
  assert_done_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R4: the poll counter never passes the budget
  assert_poll_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pollCnt) < MAX_POLLS);
endmodule

// File: rtl/mbox_dpath.sv
module mbox_dpath
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrb_t         strb,
  input  logic [1:0]        cmdSel,
  input  logic [31:0]       busRdata,
  output logic              busValid,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [31:0]       busWdata,
  output logic [31:0]       resultCode,
  output logic              resultOk,
  output logic [4:0]        errNum,
  output ptrSpace_e         ptrSpace,
  output logic [31:0]       ptrAddr
);
  logic [1:0]  cmdReg;
  logic        tmoFlag;
  logic [31:0] mboxReg;
  logic [31:0] reply [MSG_WORDS];

  logic [ADDR_W-1:0] slotAddr;
  assign slotAddr = ADDR_W'(MSG_BASE) + ADDR_W'({strb.idx, 2'b00});

  always_comb begin
    busValid = (strb.op != OP_NONE);
    busWrite = (strb.op == OP_MSGWR) || (strb.op == OP_RING) || (strb.op == OP_FREE);
    busWdata = '0;
    busAddr  = '0;
    case (strb.op)
      OP_MSGWR: begin busAddr = slotAddr; busWdata = msgWord(cmdReg, strb.idx); end
      OP_RING:  begin busAddr = ADDR_W'(TO_COP); busWdata = 32'd1; end
      OP_POLL, OP_FREE: busAddr = ADDR_W'(TO_HOST);
      OP_FETCH: busAddr = slotAddr;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdReg  <= '0;
      tmoFlag <= 1'b0;
      mboxReg <= '0;
      for (int i = 0; i < MSG_WORDS; i++) reply[i] <= '0;
    end else if (strb.launch) begin
      cmdReg  <= cmdSel;
      tmoFlag <= 1'b0;
      mboxReg <= '0;
      for (int i = 0; i < MSG_WORDS; i++) reply[i] <= '0;
    end else begin
      if (strb.timedOut) tmoFlag <= 1'b1;
      if (strb.grabMbox) mboxReg <= busRdata;
      for (int i = 0; i < MSG_WORDS; i++)
        if (strb.grabWord && strb.idx == 3'(i)) reply[i] <= busRdata;
    end
  end

  logic [31:0] sumCalc, nCode, nAddr;
  logic        nOk;
  ptrSpace_e   nSpace;

  always_comb begin
    sumCalc = reply[0] + reply[1] + reply[2] + reply[3];
    if (strb.reject)                nCode = CODE_REJ;
    else if (tmoFlag)               nCode = CODE_TMO;
    else if (sumCalc != reply[4])   nCode = CODE_CHK;
    else                            nCode = mboxReg;
    nOk    = (nCode == CODE_OK);
    nSpace = PTR_NONE;
    nAddr  = '0;
    if (nOk) begin
      case (reply[3][31:28])
        4'd1: begin nSpace = PTR_MSG;  nAddr = 32'(MSG_BASE) + {4'd0, reply[3][27:0]}; end
        4'd0: begin nSpace = PTR_DATA; nAddr = {4'd0, reply[3][27:0]}; end
        default: nSpace = PTR_BAD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resultCode <= '0;
      resultOk   <= 1'b0;
      errNum     <= '0;
      ptrSpace   <= PTR_NONE;
      ptrAddr    <= '0;
    end else if (strb.finish) begin
      resultCode <= nCode;
      resultOk   <= nOk;
      errNum     <= nOk ? 5'd0 : lowBitPos(nCode[30:0]);
      ptrSpace   <= nSpace;
      ptrAddr    <= nAddr;
    end
  end

  // R4: a timeout result never carries a pointer
  assert_tmo_no_ptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (resultCode == CODE_TMO) |-> (ptrSpace == PTR_NONE));
endmodule

// File: rtl/mbox_cmd_engine.sv
module mbox_cmd_engine
  import mbox_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MAX_POLLS = 200000,
  parameter int POLL_GAP  = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cmdSel,
  output logic              busy,
  output logic              done,
  output logic [31:0]       resultCode,
  output logic              resultOk,
  output logic [4:0]        errNum,
  output logic [1:0]        ptrSpace,
  output logic [31:0]       ptrAddr,
  output logic              busValid,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [31:0]       busWdata,
  input  logic              busReady,
  input  logic [31:0]       busRdata
);
  ctrlStrb_t strb;
  ptrSpace_e spaceInt;

  mbox_ctrl #(.MAX_POLLS(MAX_POLLS), .POLL_GAP(POLL_GAP)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cmdSel(cmdSel),
    .busReady(busReady), .pollHit(busRdata != 32'd0),
    .strb(strb), .busy(busy), .done(done)
  );

  mbox_dpath #(.ADDR_W(ADDR_W)) i_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .cmdSel(cmdSel), .busRdata(busRdata),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .resultCode(resultCode), .resultOk(resultOk), .errNum(errNum),
    .ptrSpace(spaceInt), .ptrAddr(ptrAddr)
  );

  assign ptrSpace = spaceInt;

  // R10: a stalled request holds still
  assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busValid && !busReady) |=> (busValid && $stable(busAddr) && $stable(busWrite) && $stable(busWdata)));
  // R2: no bus traffic outside a transaction
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !busValid);
  // R5: the reply mailbox release is the last operation before done
  assert_release_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && resultCode != CODE_REJ) |->
      $past(busValid && busReady && busWrite && busAddr == ADDR_W'(TO_HOST) && busWdata == 32'd0));
endmodule

// File: tb/test_mbox_cmd_engine.sv
module test_mbox_cmd_engine;
  localparam int GAP = 3;
  localparam int POLLS = 12;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, busReady = 1'b0;
  logic [1:0] cmdSel = 2'd0;
  logic busy, done, resultOk, busValid, busWrite;
  logic [31:0] resultCode, ptrAddr, busWdata, busRdata;
  logic [4:0] errNum;
  logic [1:0] ptrSpace;
  logic [15:0] busAddr;

  mbox_cmd_engine #(.ADDR_W(16), .MAX_POLLS(POLLS), .POLL_GAP(GAP)) i_mbox_cmd_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .cmdSel(cmdSel), .busy(busy), .done(done),
    .resultCode(resultCode), .resultOk(resultOk), .errNum(errNum), .ptrSpace(ptrSpace),
    .ptrAddr(ptrAddr), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busReady(busReady), .busRdata(busRdata)
  );

  always #2.5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;

  // coprocessor and memory model
  logic [31:0] ram [5];
  logic [31:0] toHost = 0;
  int mode = 0, delay = 0, cnt = 0;
  bit armed = 0;
  logic [31:0] scnCode = 1, scnArg = 0;
  logic [15:0] lgAddr [64];
  bit lgWr [64];
  logic [31:0] lgData [64];
  int lgCyc [64];
  int opN = 0;

  initial for (int i = 0; i < 5; i++) ram[i] = 0;

  assign busRdata = (busAddr == 16'h14) ? toHost :
                    (busAddr >= 16'h100 && busAddr <= 16'h110) ? ram[(busAddr - 16'h100) >> 2] : 32'd0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (busValid && busReady) begin
      if (opN < 64) begin
        lgAddr[opN] <= busAddr; lgWr[opN] <= busWrite; lgData[opN] <= busWdata; lgCyc[opN] <= cyc;
      end
      opN <= opN + 1;
      if (busWrite) begin
        if (busAddr >= 16'h100 && busAddr <= 16'h110) ram[(busAddr - 16'h100) >> 2] <= busWdata;
        if (busAddr == 16'h10 && busWdata == 1 && mode != 3) begin armed <= 1; cnt <= delay; end
        if (busAddr == 16'h14) toHost <= busWdata;
      end
    end
    if (armed) begin
      if (cnt == 0) begin
        ram[0] <= 2; ram[2] <= 1; ram[3] <= scnArg;
        ram[4] <= 32'd2 + ram[1] + 32'd1 + scnArg + ((mode == 2) ? 32'd1 : 32'd0);
        toHost <= scnCode;
        armed <= 0;
      end else cnt <= cnt - 1;
    end
  end

  always @(negedge clk) busReady = ($urandom % 4) != 0;

  task automatic chk(input bit ok, input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] ffs31(input logic [31:0] v);
    ffs31 = 0;
    for (int i = 30; i >= 0; i--) if (v[i]) ffs31 = 5'(i + 1);
  endfunction

  function automatic logic [31:0] expWord(input int c, input int i);
    logic [31:0] o, a;
    o = (c == 0) ? 1 : 2; a = (c == 2) ? 2 : 1;
    case (i) 0: return 1; 1: return o; 2: return 1; 3: return a; default: return 2 + o + a; endcase
  endfunction

  // mode: 0 reply with scnCode, 2 bad checksum, 3 no reply; collide: extra starts while busy
  task automatic runTxn(input int c, input int m, input logic [31:0] code, input logic [31:0] arg,
                        input int dly, input bit collide);
    logic [31:0] eCode, eAddr; bit eOk; logic [4:0] eErr; logic [1:0] eSp;
    int dones = 0, k = 0, p;
    mode = m; scnCode = code; scnArg = arg; delay = dly;
    @(negedge clk); opN = 0; start = 1; cmdSel = 2'(c);
    @(negedge clk); start = 0;
    if (c < 3) chk(busy === 1'b1, "R9", "busy after start", 32'(busy), 1);
    p = 0;
    while (!done) begin
      @(negedge clk); p++;
      if (collide && p == 3) begin start = 1; cmdSel = 2'd3; end else start = 0;
    end
    dones = 1;
    if (collide) begin start = 1; cmdSel = 2'((c + 1) % 3); end
    if (c >= 3) begin eCode = 32'h80000002; end
    else if (m == 3) eCode = 32'h80000010;
    else if (m == 2) eCode = 32'h80000004;
    else eCode = code;
    eOk = (eCode == 1); eErr = eOk ? 0 : ffs31(eCode);
    eSp = 0; eAddr = 0;
    if (eOk) begin
      if (arg[31:28] == 1) begin eSp = 1; eAddr = 32'h100 + {4'd0, arg[27:0]}; end
      else if (arg[31:28] == 0) begin eSp = 2; eAddr = {4'd0, arg[27:0]}; end
      else eSp = 3;
    end
    chk(resultCode === eCode, (m == 3) ? "R4" : (m == 2) ? "R6" : (c >= 3) ? "R2" : "R7", "resultCode", resultCode, eCode);
    chk(resultOk === eOk && errNum === eErr, "R7", "ok/errNum", {26'd0, resultOk, errNum}, {26'd0, eOk, eErr});
    chk(ptrSpace === eSp && ptrAddr === eAddr, "R8", "pointer", {ptrSpace, ptrAddr[29:0]}, {eSp, eAddr[29:0]});
    for (int w = 0; w < 3; w++) begin
      @(negedge clk); start = 0;
      if (done) dones++;
    end
    chk(dones == 1 && !busy, "R9", "single done, late start ignored", 32'(dones), 1);
    if (c >= 3) begin
      chk(opN == 0, "R2", "bus ops on reject", 32'(opN), 0);
      return;
    end
    for (int i = 0; i < 5; i++)
      chk(lgWr[i] && lgAddr[i] == 16'h100 + 16'(4 * i) && lgData[i] == expWord(c, i), "R1", "message word",
          lgData[i], expWord(c, i));
    chk(lgWr[5] && lgAddr[5] == 16'h10 && lgData[5] == 1, "R3", "doorbell", {lgAddr[5], lgData[5][15:0]}, 32'h00100001);
    k = 6;
    while (k < opN && k < 64 && !lgWr[k] && lgAddr[k] == 16'h14) k++;
    chk(k > 6, "R3", "polls after doorbell", 32'(k - 6), 1);
    for (int i = 7; i < k; i++)
      chk(lgCyc[i] - lgCyc[i - 1] >= GAP + 1, "R4", "poll spacing", 32'(lgCyc[i] - lgCyc[i - 1]), GAP + 1);
    if (m == 3) chk(k - 6 == POLLS, "R4", "poll count on timeout", 32'(k - 6), POLLS);
    else begin
      for (int i = 0; i < 5; i++)
        chk(!lgWr[k + i] && lgAddr[k + i] == 16'h100 + 16'(4 * i), "R6", "reply read", 32'(lgAddr[k + i]), 32'h100 + 4 * i);
      k += 5;
    end
    chk(opN == k + 1 && lgWr[k] && lgAddr[k] == 16'h14 && lgData[k] == 0, "R5", "final release", 32'(opN), 32'(k + 1));
  endtask

  initial begin
    void'($urandom(32'd77));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !busValid && resultCode == 0 && ptrSpace == 0, "R11", "reset state",
        {busy, done, busValid, ptrSpace}, 0);
    rst_n = 1;
    @(negedge clk);
    runTxn(0, 0, 1, 32'h1000_0040, 2, 0);
    runTxn(1, 0, 1, 32'h0000_1234, 0, 0);
    runTxn(2, 0, 1, 32'h1FFF_FFFF, 9, 1);
    runTxn(3, 0, 1, 0, 0, 0);
    runTxn(1, 3, 1, 0, 0, 0);
    runTxn(0, 2, 1, 32'h1000_0000, 4, 0);
    runTxn(2, 0, 32'h8000_0001, 0, 3, 0);
    runTxn(0, 0, 32'h8000_0000, 0, 1, 0);
    runTxn(1, 0, 1, 32'h5000_0008, 5, 0);
    runTxn(3, 0, 1, 0, 0, 1);
    for (int t = 0; t < 30; t++) begin
      int c, m, sel;
      logic [31:0] code, arg;
      c = $urandom % 4; m = $urandom % 4; if (m == 1) m = 0;
      sel = $urandom % 4;
      code = (sel == 0) ? 32'h8000_0008 : (sel == 1) ? ($urandom | 32'h1) : 32'd1;
      arg = {4'($urandom % 3), 28'($urandom)};
      runTxn(c, m, code, arg, $urandom % 20, ($urandom % 5) == 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog run did not end actual=%0d expected=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule